// File: doc/BRIEF.md
# Triggered Diagnostic Capture Buffers

This block is a capture engine with several independent channels. Each channel watches one address, or a run of consecutive addresses, in a monitored memory. On each control-cycle strobe it copies those words into its own region of a bulk memory. The engine does every transfer itself through its two memory ports, so no processor software sits in the data path.

A channel's region is either linear, where it stops once full, or circular, where it wraps to the start. A decimation factor lets a channel store only one strobe in N. A channel can also hold off until a signed comparison is true on another monitored word; once that comparison fires, the channel stays triggered. In reverse mode a channel plays its region back into the monitored address, one step per serviced strobe. When several channels are due on the same strobe, they are serviced one after another in ascending channel order.

Configuration uses a simple write port. `cfg_addr` holds a channel number and a field code. Each channel has these fields:

| Code | Field | Meaning |
|------|-------|---------|
| 0 | CTRL | Control bits, listed in R10 |
| 1 | SRC | Source address |
| 2 | LEN | Word count; 0 counts as 1 |
| 3 | DEC | Decimation factor |
| 4 | RSTART | Region start |
| 5 | REND | Region end (exclusive) |
| 6 | TADDR | Trigger address |
| 7 | TREF | Trigger reference value |

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset, `busy`, all flag outputs and all four memory strobes (`mon_rd`, `mon_wr`, `bulk_rd`, `bulk_wr`) are 0.
- R2: A forward channel serviced on a strobe copies monitored words SRC, SRC+1, ... into consecutive bulk addresses. The number of words is LEN, with 0 counted as 1. Writing starts at RSTART after each CTRL write and continues from where the previous strobe stopped.
- R3: For a linear channel (CTRL bit1 = 0), the write into address REND-1 sets the channel's `full_flags` bit. After that the channel makes no memory access until its CTRL is written again.
- R4: For a circular channel (CTRL bit1 = 1), the access after REND-1 goes to RSTART, and the channel's `wrap_flags` bit is set. Capture continues.
- R5: With DEC = N ≥ 2, the channel stores on the first of every N eligible strobes. DEC of 0 or 1 stores on every strobe. Strobes on which the channel is not yet triggered are not eligible.
- R6: With trigger enabled (CTRL bit3 = 1), the word at TADDR is compared, as signed 32 bits, against TREF. The operation is set by CTRL bits 5:4: 0 equal, 1 not equal, 2 less than, 3 greater than. Strobes before the comparison first holds store nothing. The strobe on which it first holds is stored.
- R7: Once triggered, a channel stays triggered, shows this on `trig_flags`, and no longer evaluates the comparison. A CTRL write clears the triggered state and `wrap_flags`/`full_flags`, and resets the pointer and decimation count.
- R8: Channels due on the same strobe are serviced in ascending channel number.
- R9: In reverse mode (CTRL bit2 = 1), each serviced strobe reads bulk words from the region pointer onward and writes them to SRC, SRC+1, .... The pointer, full and wrap rules are the same as in forward mode.
- R10: `cfg_addr[5:3]` selects the channel and `cfg_addr[2:0]` the field. Codes 6 and 7 in bits 5:3 match no channel. CTRL bit0 enables a channel; a disabled channel is never serviced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Channel number and field code |
| cfg_wdata | input | 32 | Configuration write data |
| cyc_strobe | input | 1 | Control-cycle strobe |
| mon_rd | output | 1 | Monitored memory read; data arrives one cycle later |
| mon_wr | output | 1 | Monitored memory write |
| mon_addr | output | AW | Monitored memory address |
| mon_wdata | output | 32 | Monitored memory write data |
| mon_rdata | input | 32 | Monitored memory read data |
| bulk_rd | output | 1 | Bulk memory read; data arrives one cycle later |
| bulk_wr | output | 1 | Bulk memory write |
| bulk_addr | output | BW | Bulk memory address |
| bulk_wdata | output | 32 | Bulk memory write data |
| bulk_rdata | input | 32 | Bulk memory read data |
| busy | output | 1 | Work is pending or in progress |
| full_flags | output | NCH | Linear region full, one bit per channel |
| wrap_flags | output | NCH | Circular region has wrapped, one bit per channel |
| trig_flags | output | NCH | Channel triggered, one bit per channel |

## Verification
A wrong region pointer shows up on the very next `bulk_wr` as a wrong address, so the scoreboard catches it within one strobe. A wrong decimation count or triggered state shows up as a missing or extra write on the next eligible strobe. A full flag that sets late lets an extra write escape past REND-1, which the scoreboard reports as unexpected. Reverse playback is checked by reading the monitored word back after each strobe, so a pointer error appears as a wrong value one strobe later.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
  localparam int unsigned FW = 3;

  typedef enum logic [2:0] {
    F_CTRL, F_SRC, F_LEN, F_DEC, F_RSTART, F_REND, F_TADDR, F_TREF
  } field_e;

  typedef enum logic [1:0] {CMP_EQ, CMP_NE, CMP_LT, CMP_GT} cmp_e;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_TCHK, S_DEC, S_DRD, S_DWR} st_e;

  // Control word layout, LSB first: en, circ, rev, ten, op[1:0]
  typedef struct packed {
    cmp_e op;
    logic ten;
    logic rev;
    logic circ;
    logic en;
  } ctrl_t;

  function automatic logic cmp_hit(cmp_e op, logic [31:0] a, logic [31:0] b);
    case (op)
      CMP_EQ:  return a == b;
      CMP_NE:  return a != b;
      CMP_LT:  return $signed(a) < $signed(b);
      default: return $signed(a) > $signed(b);
    endcase
  endfunction

  function automatic logic [31:0] dec_next(logic [31:0] cnt, logic [31:0] dec);
    if (dec <= 32'd1 || cnt + 32'd1 >= dec) return 32'd0;
    return cnt + 32'd1;
  endfunction

  function automatic logic [31:0] below(logic [31:0] n);
    return (32'd1 << n) - 32'd1;
  endfunction
endpackage

// File: rtl/cap_cfg_regs.sv
module cap_cfg_regs
  import trig_cap_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned AW  = 16,
  parameter int unsigned BW  = 20,
  parameter int unsigned LW  = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CW+FW-1:0]  cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output ctrl_t             ctrl_o   [NCH],
  output logic [AW-1:0]     src_o    [NCH],
  output logic [LW-1:0]     len_o    [NCH],
  output logic [DW-1:0]     dec_o    [NCH],
  output logic [BW-1:0]     rstart_o [NCH],
  output logic [BW-1:0]     rend_o   [NCH],
  output logic [AW-1:0]     taddr_o  [NCH],
  output logic [31:0]       tref_o   [NCH],
  output logic [NCH-1:0]    reinit_o
);
  field_e fld;
  assign fld = field_e'(cfg_addr[FW-1:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = cfg_we && (cfg_addr[FW +: CW] == CW'(i));
    assign reinit_o[i] = hit && (fld == F_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_o[i]   <= '0;
        src_o[i]    <= '0;
        len_o[i]    <= '0;
        dec_o[i]    <= '0;
        rstart_o[i] <= '0;
        rend_o[i]   <= '0;
        taddr_o[i]  <= '0;
        tref_o[i]   <= '0;
      end else if (hit) begin
        case (fld)
          F_CTRL:   ctrl_o[i]   <= ctrl_t'(cfg_wdata[5:0]);
          F_SRC:    src_o[i]    <= cfg_wdata[AW-1:0];
          F_LEN:    len_o[i]    <= cfg_wdata[LW-1:0];
          F_DEC:    dec_o[i]    <= cfg_wdata[DW-1:0];
          F_RSTART: rstart_o[i] <= cfg_wdata[BW-1:0];
          F_REND:   rend_o[i]   <= cfg_wdata[BW-1:0];
          F_TADDR:  taddr_o[i]  <= cfg_wdata[AW-1:0];
          default:  tref_o[i]   <= cfg_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/cap_arb.sv
module cap_arb #(
  parameter int unsigned NCH = 6,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend_i,
  output logic [NCH-1:0] grant_o,
  output logic [CW-1:0]  gidx_o,
  output logic           any_o
);
  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_pri
    assign seen[i+1]  = seen[i] | pend_i[i];
    assign grant_o[i] = pend_i[i] & ~seen[i];
  end

  always_comb begin
    gidx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_i[i]) gidx_o = CW'(i);
    end
  end

  assign any_o = seen[NCH];
endmodule

// File: rtl/cap_engine.sv
module cap_engine
  import trig_cap_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned AW  = 16,
  parameter int unsigned BW  = 20,
  parameter int unsigned LW  = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_strobe,
  input  ctrl_t          ctrl_i   [NCH],
  input  logic [AW-1:0]  src_i    [NCH],
  input  logic [LW-1:0]  len_i    [NCH],
  input  logic [DW-1:0]  dec_i    [NCH],
  input  logic [BW-1:0]  rstart_i [NCH],
  input  logic [BW-1:0]  rend_i   [NCH],
  input  logic [AW-1:0]  taddr_i  [NCH],
  input  logic [31:0]    tref_i   [NCH],
  input  logic [NCH-1:0] reinit_i,
  output logic [NCH-1:0] pend_o,
  input  logic [NCH-1:0] grant_i,
  input  logic [CW-1:0]  gidx_i,
  input  logic           any_i,
  output logic           mon_rd,
  output logic           mon_wr,
  output logic [AW-1:0]  mon_addr,
  output logic [31:0]    mon_wdata,
  input  logic [31:0]    mon_rdata,
  output logic           bulk_rd,
  output logic           bulk_wr,
  output logic [BW-1:0]  bulk_addr,
  output logic [31:0]    bulk_wdata,
  input  logic [31:0]    bulk_rdata,
  output logic           busy,
  output logic [NCH-1:0] full_o,
  output logic [NCH-1:0] wrap_o,
  output logic [NCH-1:0] trig_o
);
  st_e            state;
  logic [CW-1:0]  cur;
  logic [LW-1:0]  idx;
  logic [NCH-1:0] pend_q, full_q, wrap_q, trig_q, en_mask, clr_mask;
  logic [BW-1:0]  wp   [NCH];
  logic [DW-1:0]  dcnt [NCH];

  // Named internal events
  logic need_trig, trig_fire, take_sample, at_end, last_word;
  ctrl_t cc;

  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign en_mask[i] = ctrl_i[i].en;
  end

  assign cc          = ctrl_i[cur];
  assign need_trig   = cc.ten && !trig_q[cur];
  assign trig_fire   = (state == S_TCHK) && cmp_hit(cc.op, mon_rdata, tref_i[cur]);
  assign take_sample = (state == S_DEC) && !full_q[cur] && (dcnt[cur] == '0);
  assign at_end      = (wp[cur] + BW'(1)) == rend_i[cur];
  assign last_word   = (len_i[cur] == '0) || (idx == len_i[cur] - LW'(1));
  assign clr_mask    = (state == S_IDLE) ? grant_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      idx    <= '0;
      pend_q <= '0;
      full_q <= '0;
      wrap_q <= '0;
      trig_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        wp[i]   <= '0;
        dcnt[i] <= '0;
      end
    end else begin
      pend_q <= (pend_q & ~clr_mask) | (cyc_strobe ? en_mask : '0);
      for (int i = 0; i < NCH; i++) begin
        if (reinit_i[i]) begin
          wp[i]     <= rstart_i[i];
          dcnt[i]   <= '0;
          full_q[i] <= 1'b0;
          wrap_q[i] <= 1'b0;
          trig_q[i] <= 1'b0;
        end
      end
      case (state)
        S_IDLE: if (any_i) begin
          cur   <= gidx_i;
          state <= S_CHK;
        end
        S_CHK:  state <= need_trig ? S_TCHK : S_DEC;
        S_TCHK: begin
          if (trig_fire) begin
            trig_q[cur] <= 1'b1;
            state       <= S_DEC;
          end else begin
            state <= S_IDLE;
          end
        end
        S_DEC: begin
          if (!full_q[cur]) begin
            dcnt[cur] <= DW'(dec_next(32'(dcnt[cur]), 32'(dec_i[cur])));
          end
          idx   <= '0;
          state <= take_sample ? S_DRD : S_IDLE;
        end
        S_DRD:  state <= S_DWR;
        S_DWR: begin
          idx <= idx + LW'(1);
          if (at_end) begin
            if (cc.circ) begin
              wp[cur]     <= rstart_i[cur];
              wrap_q[cur] <= 1'b1;
            end else begin
              full_q[cur] <= 1'b1;
            end
          end else begin
            wp[cur] <= wp[cur] + BW'(1);
          end
          state <= (last_word || (at_end && !cc.circ)) ? S_IDLE : S_DRD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mon_rd     = ((state == S_CHK) && need_trig) || ((state == S_DRD) && !cc.rev);
  assign mon_wr     = (state == S_DWR) && cc.rev;
  assign mon_addr   = (state == S_CHK) ? taddr_i[cur] : src_i[cur] + AW'(idx);
  assign mon_wdata  = bulk_rdata;
  assign bulk_rd    = (state == S_DRD) && cc.rev;
  assign bulk_wr    = (state == S_DWR) && !cc.rev;
  assign bulk_addr  = wp[cur];
  assign bulk_wdata = mon_rdata;
  assign busy       = (state != S_IDLE) || (|pend_q);
  assign pend_o     = pend_q;
  assign full_o     = full_q;
  assign wrap_o     = wrap_q;
  assign trig_o     = trig_q;

  // R3
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_wr || mon_wr) |-> !full_q[cur]);

  // R2
  region_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_wr || bulk_rd) |-> (bulk_addr >= rstart_i[cur] && bulk_addr < rend_i[cur]));

  // R8
  ascending_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && |pend_q) |=> ((32'($past(pend_q)) & below(32'(cur))) == 32'd0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R7
    trig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q[i] && !reinit_i[i]) |=> trig_q[i]);
    // R4
    wrap_only_circ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q[i] |-> ctrl_i[i].circ);
    // R3
    full_only_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_q[i] |-> !ctrl_i[i].circ);
  end
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
  import trig_cap_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned AW  = 16,
  parameter int unsigned BW  = 20,
  parameter int unsigned LW  = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CW+FW-1:0]  cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cyc_strobe,
  output logic              mon_rd,
  output logic              mon_wr,
  output logic [AW-1:0]     mon_addr,
  output logic [31:0]       mon_wdata,
  input  logic [31:0]       mon_rdata,
  output logic              bulk_rd,
  output logic              bulk_wr,
  output logic [BW-1:0]     bulk_addr,
  output logic [31:0]       bulk_wdata,
  input  logic [31:0]       bulk_rdata,
  output logic              busy,
  output logic [NCH-1:0]    full_flags,
  output logic [NCH-1:0]    wrap_flags,
  output logic [NCH-1:0]    trig_flags
);
  ctrl_t          ctrl   [NCH];
  logic [AW-1:0]  src    [NCH];
  logic [LW-1:0]  len    [NCH];
  logic [DW-1:0]  dec    [NCH];
  logic [BW-1:0]  rstart [NCH];
  logic [BW-1:0]  rend   [NCH];
  logic [AW-1:0]  taddr  [NCH];
  logic [31:0]    tref   [NCH];
  logic [NCH-1:0] reinit, pend, grant;
  logic [CW-1:0]  gidx;
  logic           any;

  cap_cfg_regs #(.NCH(NCH), .AW(AW), .BW(BW), .LW(LW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_o(ctrl), .src_o(src), .len_o(len),
    .dec_o(dec), .rstart_o(rstart), .rend_o(rend), .taddr_o(taddr),
    .tref_o(tref), .reinit_o(reinit)
  );

  cap_arb #(.NCH(NCH)) u_arb (
    .pend_i(pend), .grant_o(grant), .gidx_o(gidx), .any_o(any)
  );

  cap_engine #(.NCH(NCH), .AW(AW), .BW(BW), .LW(LW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe),
    .ctrl_i(ctrl), .src_i(src), .len_i(len), .dec_i(dec),
    .rstart_i(rstart), .rend_i(rend), .taddr_i(taddr), .tref_i(tref),
    .reinit_i(reinit), .pend_o(pend), .grant_i(grant), .gidx_i(gidx),
    .any_i(any), .mon_rd(mon_rd), .mon_wr(mon_wr), .mon_addr(mon_addr),
    .mon_wdata(mon_wdata), .mon_rdata(mon_rdata), .bulk_rd(bulk_rd),
    .bulk_wr(bulk_wr), .bulk_addr(bulk_addr), .bulk_wdata(bulk_wdata),
    .bulk_rdata(bulk_rdata), .busy(busy), .full_o(full_flags),
    .wrap_o(wrap_flags), .trig_o(trig_flags)
  );
endmodule

// File: tb/trig_capture_ctrl_tb_top.sv
module trig_capture_ctrl_tb_top;
  localparam int NCH = 6;
  localparam int AW  = 8;
  localparam int BW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cyc_strobe = 1'b0;
  logic mon_rd, mon_wr, bulk_rd, bulk_wr, busy;
  logic [AW-1:0] mon_addr;
  logic [BW-1:0] bulk_addr;
  logic [31:0] mon_wdata, bulk_wdata;
  logic [31:0] mon_rdata, bulk_rdata;
  logic [NCH-1:0] full_flags, wrap_flags, trig_flags;

  logic tb_mwe = 1'b0, tb_bwe = 1'b0;
  logic [7:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] mon_mem [256];
  logic [31:0] bulk_mem [256];

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_addr_q [$];
  logic [31:0] exp_data_q [$];
  string       exp_tag_q  [$];

  always #10 clk = ~clk;

  trig_capture_ctrl #(.NCH(NCH), .AW(AW), .BW(BW), .LW(8), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cyc_strobe(cyc_strobe), .mon_rd(mon_rd),
    .mon_wr(mon_wr), .mon_addr(mon_addr), .mon_wdata(mon_wdata),
    .mon_rdata(mon_rdata), .bulk_rd(bulk_rd), .bulk_wr(bulk_wr),
    .bulk_addr(bulk_addr), .bulk_wdata(bulk_wdata), .bulk_rdata(bulk_rdata),
    .busy(busy), .full_flags(full_flags), .wrap_flags(wrap_flags),
    .trig_flags(trig_flags)
  );

  // Memory models with one-cycle read latency
  always @(posedge clk) begin
    if (tb_mwe) mon_mem[tb_addr] <= tb_data;
    else if (mon_wr) mon_mem[mon_addr] <= mon_wdata;
    if (mon_rd) mon_rdata <= mon_mem[mon_addr];
    if (tb_bwe) bulk_mem[tb_addr] <= tb_data;
    else if (bulk_wr) bulk_mem[bulk_addr] <= bulk_wdata;
    if (bulk_rd) bulk_rdata <= bulk_mem[bulk_addr];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each bulk write with the queue head
  always @(negedge clk) begin
    if (rst_n && bulk_wr) begin
      checks++;
      if (exp_addr_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected write actual=%0h:%0h expected=none", bulk_addr, bulk_wdata);
      end else begin
        logic [15:0] ea;
        logic [31:0] ed;
        string t;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        t  = exp_tag_q.pop_front();
        if (16'(bulk_addr) != ea || bulk_wdata != ed) begin
          errors++;
          $display("FAIL %s actual=%0h:%0h expected=%0h:%0h", t, bulk_addr, bulk_wdata, ea, ed);
        end
      end
    end
  end

  task automatic expect_w(input int a, input int d, input string tag);
    exp_addr_q.push_back(16'(a));
    exp_data_q.push_back(32'(d));
    exp_tag_q.push_back(tag);
  endtask

  task automatic drained(input string tag);
    check(exp_addr_q.size() == 0, tag, 32'(exp_addr_q.size()), 0);
    exp_addr_q.delete();
    exp_data_q.delete();
    exp_tag_q.delete();
  endtask

  task automatic cfg_wr(input int ch, input int fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(ch), 3'(fld)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mon(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_mwe = 1'b1; tb_addr = 8'(a); tb_data = d;
    @(negedge clk);
    tb_mwe = 1'b0;
  endtask

  task automatic set_bulk(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_bwe = 1'b1; tb_addr = 8'(a); tb_data = d;
    @(negedge clk);
    tb_bwe = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    cyc_strobe = 1'b1;
    @(negedge clk);
    cyc_strobe = 1'b0;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic chan(input int ch, input int src, input int len, input int dec,
                      input int rs, input int re, input logic [31:0] ctrl);
    cfg_wr(ch, 1, 32'(src));
    cfg_wr(ch, 2, 32'(len));
    cfg_wr(ch, 3, 32'(dec));
    cfg_wr(ch, 4, 32'(rs));
    cfg_wr(ch, 5, 32'(re));
    cfg_wr(ch, 0, ctrl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", 32'(busy), 0);
    check({full_flags, wrap_flags, trig_flags} == '0, "R1 flags",
          32'({full_flags, wrap_flags, trig_flags}), 0);
    check({mon_rd, mon_wr, bulk_rd, bulk_wr} == 4'b0, "R1 strobes",
          32'({mon_rd, mon_wr, bulk_rd, bulk_wr}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: strobe with no channel enabled produces no work
    strobe();
    check(busy == 1'b0, "R10 idle strobe", 32'(busy), 0);

    // R2/R3: linear single-word channel 0, region 100..103
    chan(0, 10, 0, 0, 100, 104, 32'h1);
    for (int k = 0; k < 6; k++) begin
      set_mon(10, 32'(1000 + k));
      if (k < 4) expect_w(100 + k, 1000 + k, k == 3 ? "R3 last slot" : "R2 linear");
      strobe();
    end
    drained("R3 no write after full");
    check(full_flags[0] == 1'b1, "R3 full flag", 32'(full_flags[0]), 1);
    check(wrap_flags[0] == 1'b0, "R3 no wrap", 32'(wrap_flags[0]), 0);
    cfg_wr(0, 0, 32'h0);
    check(full_flags[0] == 1'b0, "R7 ctrl write clears full", 32'(full_flags[0]), 0);

    // R4/R5: circular two-word vector on channel 1, decimation 2, region 120..124
    chan(1, 20, 2, 2, 120, 125, 32'h3);
    for (int k = 0; k < 5; k++) begin
      set_mon(20, 32'(2000 + 10 * k));
      set_mon(21, 32'(2001 + 10 * k));
      if (k == 0) begin
        expect_w(120, 2000, "R2 vector");
        expect_w(121, 2001, "R2 vector");
      end else if (k == 2) begin
        expect_w(122, 2020, "R5 decimation");
        expect_w(123, 2021, "R5 decimation");
      end else if (k == 4) begin
        expect_w(124, 2040, "R5 decimation");
        expect_w(120, 2041, "R4 wrap");
      end
      strobe();
      if (k == 2) check(wrap_flags[1] == 1'b0, "R4 before wrap", 32'(wrap_flags[1]), 0);
    end
    drained("R5 skipped strobes");
    check(wrap_flags[1] == 1'b1, "R4 wrap flag", 32'(wrap_flags[1]), 1);
    check(full_flags[1] == 1'b0, "R4 no full", 32'(full_flags[1]), 0);
    cfg_wr(1, 0, 32'h0);

    // R6/R7: channel 2 triggered on signed greater-than 50
    cfg_wr(2, 6, 32'd30);
    cfg_wr(2, 7, 32'd50);
    chan(2, 31, 1, 0, 130, 140, 32'h39);
    set_mon(30, 32'hFFFF_FFFB);
    set_mon(31, 32'd3000);
    strobe();
    check(trig_flags[2] == 1'b0, "R6 signed compare not met", 32'(trig_flags[2]), 0);
    set_mon(30, 32'd60);
    set_mon(31, 32'd3001);
    expect_w(130, 3001, "R6 firing strobe stored");
    strobe();
    check(trig_flags[2] == 1'b1, "R6 trigger fired", 32'(trig_flags[2]), 1);
    set_mon(30, 32'd0);
    set_mon(31, 32'd3002);
    expect_w(131, 3002, "R7 sticky trigger");
    strobe();
    drained("R6 pre-trigger strobe stored nothing");
    // Re-arm with less-than 0
    cfg_wr(2, 7, 32'd0);
    cfg_wr(2, 0, 32'h29);
    check(trig_flags[2] == 1'b0, "R7 ctrl write clears trigger", 32'(trig_flags[2]), 0);
    set_mon(30, 32'd5);
    set_mon(31, 32'd3003);
    strobe();
    set_mon(30, 32'hFFFF_FFFF);
    set_mon(31, 32'd3004);
    expect_w(130, 3004, "R6 less-than fires, pointer reset");
    strobe();
    drained("R6 less-than");
    cfg_wr(2, 0, 32'h0);

    // R8: channels 4 and 3 due together, serviced in ascending order
    chan(4, 51, 1, 0, 160, 170, 32'h1);
    chan(3, 50, 1, 0, 150, 160, 32'h1);
    set_mon(50, 32'd5000);
    set_mon(51, 32'd5100);
    expect_w(150, 5000, "R8 channel 3 first");
    expect_w(160, 5100, "R8 channel 4 second");
    strobe();
    drained("R8 order");
    cfg_wr(3, 0, 32'h0);
    cfg_wr(4, 0, 32'h0);

    // R10: channel code 7 selects nothing
    cfg_wr(7, 0, 32'h1);
    strobe();
    check(busy == 1'b0, "R10 code 7 ignored", 32'(busy), 0);
    drained("R10 code 7 no writes");

    // R9: reverse playback on channel 5, linear region 200..201
    set_bulk(200, 32'd7000);
    set_bulk(201, 32'd7001);
    set_mon(40, 32'd0);
    chan(5, 40, 1, 0, 200, 202, 32'h5);
    strobe();
    check(mon_mem[40] == 32'd7000, "R9 first playback", mon_mem[40], 32'd7000);
    strobe();
    check(mon_mem[40] == 32'd7001, "R9 second playback", mon_mem[40], 32'd7001);
    check(full_flags[5] == 1'b1, "R9 reverse full", 32'(full_flags[5]), 1);
    set_mon(40, 32'd42);
    strobe();
    check(mon_mem[40] == 32'd42, "R3 reverse stops when full", mon_mem[40], 32'd42);
    drained("R9 no bulk writes in reverse");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule